// File: doc/BRIEF.md
# Collision Statistics Register with Half-Range Warning

This block is a 16-bit statistics word that a MAC places in its register map to tally transmit collisions. The MAC sends a one-cycle pulse for every collision it sees. Each pulse adds one to a 10-bit tally kept in the upper bits of the word. The six lowest bits never change. They carry a fixed code that lets software confirm which register it has read.

A host reads the word with a single-cycle read strobe. During that strobe cycle the word is presented on the read data port. On the following edge the tally clears to zero. Because of this clear-on-read behaviour, the tally wraps silently after 3FFh. To let software read the tally well before it wraps, an optional early-warning interrupt can be enabled. It fires when the tally steps from 1FFh to 200h, which leaves 512 further events before wrap-around. The interrupt flag is sticky and is cleared by the next read.

Top module: `col_stat_reg`

## Requirements
- R1: After reset, rd_data reads 16'h0012 (tally zero, code in the low bits) and irq is low.
- R2: rd_data[5:0] always reads the constant code 6'b010010, with the LSB at bit 0. The tally occupies rd_data[15:6].
- R3: When col_evt is high and rd_strobe is low, the tally shown on rd_data[15:6] rises by one at the next clock edge. With neither input high, the tally holds.
- R4: rd_data is valid in the same cycle as rd_strobe. After that edge the tally reads zero when no event coincides with the read.
- R5: When col_evt and rd_strobe are both high in one cycle, the read returns the old tally and the tally becomes 1, so no event is lost.
- R6: An event counted while the tally is 3FFh wraps the tally to 0.
- R7: With int_en high, an event that moves the tally from 1FFh to 200h sets irq at that edge.
- R8: Once set, irq stays high until a read. The edge that ends a rd_strobe cycle clears it.
- R9: With int_en low, the 1FFh-to-200h step leaves irq low, and the tally keeps counting normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| col_evt | input | 1 | One-cycle collision event pulse |
| int_en | input | 1 | Enables the half-range warning flag |
| rd_strobe | input | 1 | Host read; clears tally and flag at the next edge |
| rd_data | output | 16 | Register word: tally in [15:6], code in [5:0] |
| irq | output | 1 | Sticky half-range warning |

## Verification
Several event patterns drive the tally: isolated pulses separated by idle cycles, back-to-back bursts, a read alone, and a read that coincides with an event. Together these separate a correct increment from hold, clear and clear-plus-one. Long bursts with the enable set and then with it clear walk the tally through the 1FFh-to-200h step. This shows that the flag depends on the enable and not on the tally alone. A run up to 3FFh and one event further shows the wrap to zero. Reads issued while irq is pending show that the flag is sticky and that a read clears it.

// File: rtl/col_stat_pkg.sv
package col_stat_pkg;
  localparam int unsigned DEF_DATA_W  = 16;
  localparam int unsigned DEF_ID_W    = 6;
  localparam int unsigned DEF_CNT_W   = DEF_DATA_W - DEF_ID_W;
  localparam logic [DEF_ID_W-1:0] DEF_ID_CODE = 6'b010010;
endpackage

// File: rtl/col_stat_cnt.sv
module col_stat_cnt #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_d;
  logic             count_en;

  always_comb begin
    count_en = inc | clr;
    unique case ({clr, inc})
      2'b11:   count_d = ONE;
      2'b10:   count_d = '0;
      2'b01:   count_d = count_q + ONE;
      default: count_d = count_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (count_en) begin
      count_q <= count_d;
    end
  end

  assign count = count_q;
endmodule

// File: rtl/col_stat_warn.sv
module col_stat_warn #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic             inc,
  input  logic             clr,
  input  logic             en,
  output logic             flag
);
  localparam logic [CNT_W-1:0] BELOW_HALF = {1'b0, {(CNT_W-1){1'b1}}};

  logic flag_q;
  logic flag_d;
  logic set_req;
  logic flag_en;

  always_comb begin
    set_req = en & inc & ~clr & (count == BELOW_HALF);
    flag_en = set_req | clr;
    flag_d  = set_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/col_stat_word.sv
module col_stat_word #(
  parameter int unsigned CNT_W  = 10,
  parameter int unsigned ID_W   = 6,
  parameter logic [ID_W-1:0] ID_CODE = 6'b010010,
  localparam int unsigned DATA_W = CNT_W + ID_W
) (
  input  logic [CNT_W-1:0]  count,
  output logic [DATA_W-1:0] word
);
  assign word = {count, ID_CODE};
endmodule

// File: rtl/col_stat_reg.sv
module col_stat_reg
  import col_stat_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned ID_W   = DEF_ID_W,
  parameter logic [ID_W-1:0] ID_CODE = DEF_ID_CODE,
  localparam int unsigned CNT_W = DATA_W - ID_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              col_evt,
  input  logic              int_en,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  logic [CNT_W-1:0] tally;

  col_stat_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (col_evt),
    .clr   (rd_strobe),
    .count (tally)
  );

  col_stat_warn #(.CNT_W(CNT_W)) u_warn (
    .clk   (clk),
    .rst_n (rst_n),
    .count (tally),
    .inc   (col_evt),
    .clr   (rd_strobe),
    .en    (int_en),
    .flag  (irq)
  );

  col_stat_word #(.CNT_W(CNT_W), .ID_W(ID_W), .ID_CODE(ID_CODE)) u_word (
    .count (tally),
    .word  (rd_data)
  );
endmodule

// File: rtl/col_stat_chk.sv
module col_stat_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ID_W   = 6,
  parameter logic [ID_W-1:0] ID_CODE = 6'b010010,
  localparam int unsigned CNT_W = DATA_W - ID_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              col_evt,
  input logic              int_en,
  input logic              rd_strobe,
  input logic [DATA_W-1:0] rd_data,
  input logic              irq
);
  localparam logic [CNT_W-1:0] HALF_M1 = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic [CNT_W-1:0] TOP     = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE     = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt;
  assign cnt = rd_data[DATA_W-1:ID_W];

  assert_id_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[ID_W-1:0] == ID_CODE);

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (col_evt && !rd_strobe) |=> cnt == $past(cnt) + ONE);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!col_evt && !rd_strobe) |=> $stable(cnt));

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !col_evt) |=> cnt == '0);

  assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && col_evt) |=> cnt == ONE);

  assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (col_evt && !rd_strobe && cnt == TOP) |=> cnt == '0);

  assert_warn_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (int_en && col_evt && !rd_strobe && cnt == HALF_M1) |=> irq);

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !rd_strobe) |=> irq);

  assert_read_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |=> !irq);

  assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !(int_en && col_evt && !rd_strobe && cnt == HALF_M1)) |=> !irq);
endmodule

bind col_stat_reg col_stat_chk #(.DATA_W(DATA_W), .ID_W(ID_W), .ID_CODE(ID_CODE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .col_evt   (col_evt),
  .int_en    (int_en),
  .rd_strobe (rd_strobe),
  .rd_data   (rd_data),
  .irq       (irq)
);

// File: tb/tb_col_stat_reg.sv
`timescale 1ns/1ps
module tb_col_stat_reg;
  logic        clk;
  logic        rst_n;
  logic        col_evt;
  logic        int_en;
  logic        rd_strobe;
  logic [15:0] rd_data;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  string phase = "R1";
  bit done = 0;

  int m_cnt;
  bit m_irq;

  col_stat_reg dut (
    .clk(clk), .rst_n(rst_n), .col_evt(col_evt), .int_en(int_en),
    .rd_strobe(rd_strobe), .rd_data(rd_data), .irq(irq)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  // Behavioural reference: integer tally modulo 1024, sticky flag
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0;
      m_irq <= 0;
    end else begin
      if (rd_strobe) m_cnt <= col_evt ? 1 : 0;
      else if (col_evt) m_cnt <= (m_cnt + 1) % 1024;
      if (rd_strobe) m_irq <= 0;
      else if (int_en && col_evt && m_cnt == 511) m_irq <= 1;
    end
  end

  task automatic check16(string req, logic [15:0] act, logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle compare against the model on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check16({phase, " word"}, rd_data, {m_cnt[9:0], 6'b010010});
      check16({phase, " irq"}, {15'd0, irq}, {15'd0, m_irq});
    end
  end

  task automatic cyc(bit ev, bit rd);
    @(posedge clk); #1;
    col_evt = ev; rd_strobe = rd;
  endtask

  task automatic burst(int n);
    for (int i = 0; i < n; i++) cyc(1, 0);
    cyc(0, 0);
  endtask

  initial begin
    #2_000_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 0; col_evt = 0; int_en = 0; rd_strobe = 0;
    #23;
    check16("R1 reset word", rd_data, 16'h0012);
    check16("R1 reset irq", {15'd0, irq}, 16'd0);
    @(negedge clk); rst_n = 1;

    phase = "R3 isolated";
    for (int i = 0; i < 5; i++) begin cyc(1, 0); cyc(0, 0); cyc(0, 0); end
    phase = "R3 burst";
    burst(7);
    @(negedge clk);
    check16("R3 tally 12", rd_data, {10'd12, 6'b010010});
    check16("R2 code", {10'd0, rd_data[5:0]}, 16'h0012);

    phase = "R4 read";
    cyc(0, 1);
    @(negedge clk); check16("R4 read value", rd_data, {10'd12, 6'b010010});
    cyc(0, 0);
    @(negedge clk); check16("R4 cleared", rd_data, 16'h0012);

    phase = "R5 coincide";
    burst(3);
    cyc(1, 1);
    @(negedge clk); check16("R5 old value", rd_data, {10'd3, 6'b010010});
    cyc(0, 0);
    @(negedge clk); check16("R5 restart 1", rd_data, {10'd1, 6'b010010});

    phase = "R7 enabled";
    int_en = 1;
    burst(510);
    @(negedge clk);
    check16("R7 at 1FF", rd_data, {10'h1FF, 6'b010010});
    check16("R7 irq before", {15'd0, irq}, 16'd0);
    burst(1);
    @(negedge clk);
    check16("R7 irq set", {15'd0, irq}, 16'd1);
    phase = "R8 sticky";
    int_en = 0;
    burst(20);
    @(negedge clk); check16("R8 irq held", {15'd0, irq}, 16'd1);
    cyc(0, 1); cyc(0, 0);
    @(negedge clk); check16("R8 irq cleared", {15'd0, irq}, 16'd0);

    phase = "R9 disabled";
    burst(530);
    @(negedge clk);
    check16("R9 no irq", {15'd0, irq}, 16'd0);
    check16("R9 tally", rd_data, {10'd530, 6'b010010});

    phase = "R6 wrap";
    burst(1023 - 530);
    @(negedge clk); check16("R6 at 3FF", rd_data, {10'h3FF, 6'b010010});
    burst(1);
    @(negedge clk); check16("R6 wrapped", rd_data, 16'h0012);
    check16("R6 irq", {15'd0, irq}, 16'd0);

    repeat (3) @(posedge clk);
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule